// File: doc/BRIEF.md
# Key-Sequenced Watchdog Reset Controller

This block is a watchdog that asks for a system reset when software stops servicing it. A 64-bit count is built from two chained 32-bit halves and compared against a 64-bit period. Software programs the count, the period and a global configuration word over a write-only register bus. It then arms the watchdog with an ordered pair of key writes to a control word.

Once armed, the count advances by one on every clock. Writing the same two keys again in order restarts the count from zero, and that is how software services the watchdog. A write of any unexpected key while armed asks for a reset at once. So does the count reaching the period.

The reset request is a fixed pulse. After it, the block stays latched and does nothing more until its own reset input is asserted. The only output is the reset request.

Top module: `keyed_wdog`

## Requirements
- R1: While `rst_n` is low and after it is released, the controller is idle and `rst_req` is low. `rst_req` is high only after the controller has fired.
- R2: The writable words are at these byte addresses on `bus_addr`:
  - 0x00: count bits 31:0.
  - 0x04: count bits 63:32.
  - 0x08: period bits 31:0.
  - 0x0C: period bits 63:32.
  - 0x10: configuration. Bits 3:2 hold the mode, and 2 selects watchdog. Bits 0 and 1 release the low and high halves.
  - 0x28: control. Bit 14 is enable and bits 31:16 are the key.
  - A write to any other address has no effect.
- R3: In the idle state, a control write with key 0xA5C6 and enable set moves the controller to pre-active. This happens only when the mode is 2 and both release bits are 1. Otherwise the write is ignored and the controller stays idle. A key write while idle never asks for a reset.
- R4: In pre-active, a control write with key 0xDA7E makes the controller active. Any other key returns it to idle without a reset.
- R5: Enable is sticky. Once a first-key write with bit 14 set has been accepted, later control writes with bit 14 clear still let the sequence proceed.
- R6: While active, the count rises by one per clock, with a carry from the low half into the high half. The count is C when the 0xDA7E write is captured, and the period is P (with P ≥ C). `rst_req` rises P−C+1 clock edges after that capture.
- R7: While active, a write of 0xA5C6 followed by a write of 0xDA7E clears the count to zero. The next expiry is then P+1 edges after the 0xDA7E capture.
- R8: While active, a control write with a key other than the one expected next asks for a reset. Expected next means 0xA5C6 first, then 0xDA7E. `rst_req` is high in the cycle right after the capturing edge.
- R9: The reset request is high for exactly 16 consecutive clock cycles.
- R10: After firing, the controller is latched. No write produces a second pulse, and `rst_req` stays low until `rst_n` is asserted.
- R11: Writes to the count, period or configuration words are honoured only in the idle state. From pre-active on, they leave expiry timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the controller |
| bus_wr | input | 1 | Write strobe, captured on the rising clock edge |
| bus_addr | input | 8 | Byte address of the written word |
| bus_wdata | input | 32 | Write data |
| rst_req | output | 1 | System reset request pulse |

## Verification
Every result is registered once behind the write or count that causes it.

- A bad key captured at edge W shows `rst_req` high at the following falling edge, so latency is zero.
- An expiry shows `rst_req` high P−C+1 edges after the arming capture, or P+1 edges after a service capture.
- The pulse then lasts 16 cycles.

The bench drives writes on falling edges and keeps a free-running edge counter. It records the counter value right after the capturing edge and samples `rst_req` on each falling edge, so every latency is measured as an exact edge count and compared with the formula. A sweep over small periods and preloads covers the timing rule. Directed cases cover the count carry, refused arming, the key-order errors, the register lock and the latch.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

  localparam logic [15:0] KEY_FIRST  = 16'hA5C6;
  localparam logic [15:0] KEY_SECOND = 16'hDA7E;
  localparam logic [1:0]  MODE_WDOG  = 2'd2;

  typedef enum logic [2:0] {
    WS_IDLE  = 3'd0,
    WS_PRE   = 3'd1,
    WS_RUN   = 3'd2,
    WS_SVC   = 3'd3,
    WS_FIRED = 3'd4
  } wd_state_t;

  // Configuration word decode: mode field and both release bits.
  function automatic logic cfg_allows_arming(input logic [1:0] mode, input logic [1:0] rel);
    return (mode == MODE_WDOG) && (rel == 2'b11);
  endfunction

  // Cycles from arming to a reset request, for a count C and a period P.
  function automatic longint unsigned cycles_to_expiry(input longint unsigned c,
                                                       input longint unsigned p);
    return p - c + 64'd1;
  endfunction

endpackage

// File: rtl/wdk_cfg.sv
module wdk_cfg #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int HALF_W   = 32,
  parameter int NHALF    = 2,
  parameter int CNT_BASE = 'h00,
  parameter int PRD_BASE = 'h08,
  parameter int CFG_ADDR = 'h10,
  parameter int CTL_ADDR = 'h28
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  input  logic                     idle,
  output logic [HALF_W*NHALF-1:0]  period,
  output logic [NHALF-1:0]         cnt_ld,
  output logic [HALF_W-1:0]        cnt_ld_data,
  output logic                     cfg_ok,
  output logic                     ctl_wr
);
  import wdk_pkg::*;

  localparam int STRIDE = 4;

  logic [1:0] mode_q;
  logic [1:0] rel_q;
  logic       cfg_hit;

  assign cfg_hit     = bus_wr && (bus_addr == ADDR_W'(CFG_ADDR));
  assign ctl_wr      = bus_wr && (bus_addr == ADDR_W'(CTL_ADDR));
  assign cnt_ld_data = bus_wdata[HALF_W-1:0];
  assign cfg_ok      = cfg_allows_arming(mode_q, rel_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      rel_q  <= '0;
    end else if (cfg_hit && idle) begin
      mode_q <= bus_wdata[3:2];
      rel_q  <= bus_wdata[1:0];
    end
  end

  for (genvar g = 0; g < NHALF; g++) begin : g_half
    localparam int PRD_OFF = PRD_BASE + STRIDE * g;
    localparam int CNT_OFF = CNT_BASE + STRIDE * g;
    logic [HALF_W-1:0] prd_q;
    logic              prd_hit;

    assign prd_hit = bus_wr && (bus_addr == ADDR_W'(PRD_OFF));
    assign cnt_ld[g] = idle && bus_wr && (bus_addr == ADDR_W'(CNT_OFF));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              prd_q <= '0;
      else if (prd_hit && idle) prd_q <= bus_wdata[HALF_W-1:0];
    end

    assign period[g*HALF_W +: HALF_W] = prd_q;
  end

  // R11: once out of idle, the period holds.
  a_r11_period_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(period));

  // R11: the configuration holds once out of idle.
  a_r11_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> ($stable(mode_q) && $stable(rel_q)));

endmodule

// File: rtl/wdk_chain.sv
module wdk_chain #(
  parameter int HALF_W = 32,
  parameter int NHALF  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  logic                    clear,
  input  logic [NHALF-1:0]        ld,
  input  logic [HALF_W-1:0]       ld_data,
  input  logic [HALF_W*NHALF-1:0] period,
  output logic [HALF_W*NHALF-1:0] count,
  output logic                    expire
);
  localparam int CNT_W = HALF_W * NHALF;

  logic [NHALF:0] carry;
  assign carry[0] = run;

  for (genvar g = 0; g < NHALF; g++) begin : g_seg
    logic [HALF_W-1:0] seg_q;

    assign carry[g+1] = carry[g] && (&seg_q);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        seg_q <= '0;
      else if (clear)    seg_q <= '0;
      else if (ld[g])    seg_q <= ld_data;
      else if (carry[g]) seg_q <= seg_q + HALF_W'(1);
    end

    assign count[g*HALF_W +: HALF_W] = seg_q;
  end

  assign expire = run && (count == period);

  // R6: the count advances by exactly one per armed cycle.
  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clear && (ld == '0)) |=> (count == $past(count) + CNT_W'(1)));

  // R7: a service clears the count.
  a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == '0));

endmodule

// File: rtl/wdk_keys.sv
module wdk_keys (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_wr,
  input  logic [15:0]         key,
  input  logic                en_in,
  input  logic                cfg_ok,
  input  logic                expire,
  output wdk_pkg::wd_state_t  state,
  output logic                idle,
  output logic                run,
  output logic                svc_clear,
  output logic                fire
);
  import wdk_pkg::*;

  wd_state_t state_q, state_d;
  logic      en_q;

  always_comb begin
    state_d   = state_q;
    svc_clear = 1'b0;
    unique case (state_q)
      WS_IDLE: begin
        if (ctl_wr && key == KEY_FIRST && (en_in || en_q) && cfg_ok)
          state_d = WS_PRE;
      end
      WS_PRE: begin
        if (ctl_wr) state_d = (key == KEY_SECOND) ? WS_RUN : WS_IDLE;
      end
      WS_RUN: begin
        if (expire)      state_d = WS_FIRED;
        else if (ctl_wr) state_d = (key == KEY_FIRST) ? WS_SVC : WS_FIRED;
      end
      WS_SVC: begin
        if (expire) state_d = WS_FIRED;
        else if (ctl_wr) begin
          if (key == KEY_SECOND) begin
            state_d   = WS_RUN;
            svc_clear = 1'b1;
          end else begin
            state_d = WS_FIRED;
          end
        end
      end
      default: state_d = WS_FIRED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WS_IDLE;
      en_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == WS_IDLE && state_d == WS_PRE) en_q <= 1'b1;
    end
  end

  assign state = state_q;
  assign idle  = (state_q == WS_IDLE);
  assign run   = (state_q == WS_RUN) || (state_q == WS_SVC);
  assign fire  = (state_q != WS_FIRED) && (state_d == WS_FIRED);

  a_r10_fired_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WS_FIRED) |=> (state_q == WS_FIRED));

  a_r8_bad_first_key: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WS_RUN && ctl_wr && key != KEY_FIRST) |=> (state_q == WS_FIRED));

  a_r8_bad_second_key: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WS_SVC && ctl_wr && key != KEY_SECOND) |=> (state_q == WS_FIRED));

  a_r3_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WS_IDLE && !cfg_ok) |=> (state_q == WS_IDLE));

  a_r4_pre_no_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WS_PRE) |=> (state_q != WS_FIRED));

  a_r5_en_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q);

endmodule

// File: rtl/wdk_stretch.sv
module wdk_stretch #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  localparam int CW = $clog2(LEN + 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (fire && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == CW'(LEN - 1)) busy_q <= 1'b0;
      else                       cnt_q  <= cnt_q + CW'(1);
    end
  end

  assign pulse = busy_q;

  a_r9_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(cnt_q) == CW'(LEN - 1)));

  a_r10_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !fire);

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int HALF_W    = 32,
  parameter int NHALF     = 2,
  parameter int PULSE_LEN = 16,
  parameter int KEY_LSB   = 16,
  parameter int EN_BIT    = 14,
  parameter int CNT_BASE  = 'h00,
  parameter int PRD_BASE  = 'h08,
  parameter int CFG_ADDR  = 'h10,
  parameter int CTL_ADDR  = 'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rst_req
);
  import wdk_pkg::*;

  localparam int CNT_W = HALF_W * NHALF;

  logic [CNT_W-1:0]  period;
  logic [CNT_W-1:0]  count;
  logic [NHALF-1:0]  cnt_ld;
  logic [HALF_W-1:0] cnt_ld_data;
  logic              cfg_ok, ctl_wr, idle, run, svc_clear, fire, expire;
  wd_state_t         state;

  wdk_cfg #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .HALF_W(HALF_W), .NHALF(NHALF),
    .CNT_BASE(CNT_BASE), .PRD_BASE(PRD_BASE), .CFG_ADDR(CFG_ADDR), .CTL_ADDR(CTL_ADDR)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .idle(idle), .period(period), .cnt_ld(cnt_ld),
    .cnt_ld_data(cnt_ld_data), .cfg_ok(cfg_ok), .ctl_wr(ctl_wr)
  );

  wdk_chain #(.HALF_W(HALF_W), .NHALF(NHALF)) u_chain (
    .clk(clk), .rst_n(rst_n), .run(run), .clear(svc_clear), .ld(cnt_ld),
    .ld_data(cnt_ld_data), .period(period), .count(count), .expire(expire)
  );

  wdk_keys u_keys (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr),
    .key(bus_wdata[KEY_LSB +: 16]), .en_in(bus_wdata[EN_BIT]),
    .cfg_ok(cfg_ok), .expire(expire), .state(state), .idle(idle),
    .run(run), .svc_clear(svc_clear), .fire(fire)
  );

  wdk_stretch #(.LEN(PULSE_LEN)) u_stretch (
    .clk(clk), .rst_n(rst_n), .fire(fire), .pulse(rst_req)
  );

  // R1: a reset request only follows a firing.
  a_r1_req_needs_fire: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (state == WS_FIRED));

  // R11: the count cannot be loaded while armed.
  a_r11_no_load_armed: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_ld == '0));

endmodule

// File: tb/sim_keyed_wdog.sv
module sim_keyed_wdog;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rst_req;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int t0 = 0;
  bit done = 0;

  localparam logic [31:0] W_ARM  = 32'hA5C6_4000;
  localparam logic [31:0] W_GO   = 32'hDA7E_4000;
  localparam logic [31:0] W_GO0  = 32'hDA7E_0000;
  localparam logic [31:0] W_ARM0 = 32'hA5C6_0000;
  localparam logic [31:0] CFG_OK = 32'h0000_000B;

  keyed_wdog u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rst_req(rst_req)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_rst();
    @(negedge clk);
    rst_n = 1'b0;
    bus_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1;
    bus_addr = a;
    bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic setup(input longint unsigned p, input longint unsigned c, input logic [31:0] cfg);
    do_rst();
    wr(8'h10, cfg);
    wr(8'h08, p[31:0]);
    wr(8'h0C, p[63:32]);
    wr(8'h00, c[31:0]);
    wr(8'h04, c[63:32]);
  endtask

  task automatic arm();
    wr(8'h28, W_ARM);
    wr(8'h28, W_GO);
    t0 = cyc;
  endtask

  // Edges from t0 until rst_req is seen high, or -1 within limit.
  task automatic wait_req(input int limit, output int lat);
    while (!rst_req && (cyc - t0) < limit) @(negedge clk);
    lat = rst_req ? (cyc - t0) : -1;
  endtask

  task automatic width(output int w);
    w = 0;
    while (rst_req && w < 100) begin
      @(negedge clk);
      w++;
    end
  endtask

  initial begin
    wait (cyc >= 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lat, w;
    longint unsigned p, c;

    // R1: reset state
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(rst_req == 1'b0, "R1 low in reset", rst_req, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(rst_req == 1'b0, "R1 low after reset", rst_req, 0);

    // R6 / R9 / R2: sweep of period and preload
    for (int pi = 0; pi <= 12; pi++) begin
      for (int ci = 0; ci <= pi; ci += 2) begin
        setup(longint'(pi), longint'(ci), CFG_OK);
        arm();
        wait_req(200, lat);
        check(lat == pi - ci + 1, "R6 expiry latency", lat, pi - ci + 1);
        width(w);
        check(w == 16, "R9 pulse width", w, 16);
      end
    end

    // R6: carry from low half into high half
    p = 64'h1_0000_0002;
    c = 64'h0_FFFF_FFFE;
    setup(p, c, CFG_OK);
    arm();
    wait_req(100, lat);
    check(lat == int'(p - c + 1), "R6 carry latency", lat, p - c + 1);

    // R3: wrong mode, missing release, enable clear -> no arming
    setup(3, 0, 32'h0000_0007);
    arm();
    wait_req(40, lat);
    check(lat == -1, "R3 mode not watchdog", lat, -1);
    setup(3, 0, 32'h0000_0009);
    arm();
    wait_req(40, lat);
    check(lat == -1, "R3 one half held", lat, -1);
    setup(3, 0, CFG_OK);
    wr(8'h28, W_ARM0);
    wr(8'h28, W_GO);
    t0 = cyc;
    wait_req(40, lat);
    check(lat == -1, "R3 enable clear ignored", lat, -1);
    wr(8'h28, 32'h0000_4000);
    check(rst_req == 1'b0, "R3 idle bad key no reset", rst_req, 0);
    arm();
    wait_req(40, lat);
    check(lat == 4, "R3 arm after refusals", lat, 4);

    // R4: wrong key in pre-active returns to idle
    setup(3, 0, CFG_OK);
    wr(8'h28, W_ARM);
    wr(8'h28, 32'h1234_4000);
    check(rst_req == 1'b0, "R4 pre-active bad key no reset", rst_req, 0);
    wr(8'h28, W_GO);
    t0 = cyc;
    wait_req(40, lat);
    check(lat == -1, "R4 back to idle", lat, -1);
    arm();
    wait_req(40, lat);
    check(lat == 4, "R4 rearm latency", lat, 4);

    // R5: enable sticky
    setup(5, 1, CFG_OK);
    wr(8'h28, W_ARM);
    wr(8'h28, W_GO0);
    t0 = cyc;
    wait_req(40, lat);
    check(lat == 5, "R5 second key with enable clear", lat, 5);

    // R7: servicing
    setup(10, 0, CFG_OK);
    arm();
    for (int k = 0; k < 5; k++) begin
      wr(8'h28, W_ARM);
      wr(8'h28, W_GO);
      t0 = cyc;
      check(rst_req == 1'b0, "R7 serviced no reset", rst_req, 0);
    end
    wait_req(60, lat);
    check(lat == 11, "R7 expiry after service", lat, 11);

    // R8: bad key while active
    setup(50, 0, CFG_OK);
    arm();
    wr(8'h28, 32'h0000_4000);
    check(rst_req == 1'b1, "R8 bad key immediate", rst_req, 1);
    width(w);
    check(w == 16, "R9 bad key pulse width", w, 16);

    // R10: latched after firing
    wr(8'h28, W_ARM);
    wr(8'h28, W_GO);
    wr(8'h28, 32'h5555_4000);
    t0 = cyc;
    wait_req(40, lat);
    check(lat == -1, "R10 latched", lat, -1);

    setup(50, 0, CFG_OK);
    arm();
    wr(8'h28, W_ARM);
    wr(8'h28, 32'h0BAD_4000);
    check(rst_req == 1'b1, "R8 bad second service key", rst_req, 1);

    // R11 / R2: locked registers and unmapped address while active
    setup(8, 0, CFG_OK);
    arm();
    wr(8'h08, 32'd100);
    wr(8'h00, 32'd0);
    wr(8'h10, 32'd0);
    wr(8'h20, W_GO);
    wait_req(60, lat);
    check(lat == 9, "R11 locked registers", lat, 9);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule